// File: doc/BRIEF.md
# Event-State PQ Page Handler

This block holds two 2-bit event-state fields for each of a set of event queues: one gating notifications and one gating escalations. Software reaches a field through a pair of memory pages per queue. The even page holds the notification field and the odd page holds the escalation field. The low twelve bits of an 8-byte load or store choose the operation. Loads can acknowledge (EOI), query or overwrite the field. Stores can trigger, acknowledge, or inject a forwarding request without touching the state.

Every access is handled in the cycle it is presented. Load data, a notify pulse for stores that lead to forwarding, and an update strobe carrying any changed field value all appear on registered outputs one cycle later. Routing of the forwarded event belongs to the consumer of the notify outputs. An access to a disabled or out-of-range queue, an access whose size is not 8 bytes, or a store to an undecoded offset changes nothing. A load of that kind returns all ones.

In each field, bit 1 is P (pending) and bit 0 is Q (queued).

Top module: `pq_page_ctl`

## Requirements
- R1: After reset every field of every queue is 00, and `rd_valid`, `notify_valid` and `upd_valid` are low.
- R2: The queue index is `acc_addr >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` selects the field: 0 selects the notification field and 1 selects the escalation field. The operation comes from `acc_addr[11:0]` only, and an operation on one field never changes the other.
- R3: A load at offset 0x000–0x7FF performs EOI with the transitions 00→00, 10→00, 11→10 and 01→00. It returns the old Q bit in `rd_data[0]`, with all other data bits zero.
- R4: A load at offset 0x800–0xBFF returns the current field in `rd_data[1:0]` and leaves it unchanged.
- R5: A load at offset 0xC00–0xFFF sets the field to `acc_addr[9:8]` and returns the old value.
- R6: A store at offset 0x000–0x3FF triggers the field with the transitions 00→10 (forwarding), 10→11, 01→11 and 11→11. When it forwards, `notify_valid` pulses with the queue index and the page in `notify_esc`.
- R7: A store at offset 0x400–0x7FF performs the EOI transitions of R3 and forwards only when the old Q bit was 1.
- R8: A store at offset 0x800–0xBFF on a notification page pulses `notify_valid` and leaves the field unchanged.
- R9: A store at offset 0x800–0xBFF on an escalation page is rejected: no notify and no state change.
- R10: A disabled queue (`queue_enable` bit low), an out-of-range queue, an access size other than 8, or a store at offset 0xC00–0xFFF changes no state and raises no notify. A load of that kind returns all ones.
- R11: `upd_valid` pulses only when a field actually changes value, with the queue, page and new value on `upd_queue`, `upd_esc` and `upd_pq`.
- R12: All outputs are registered and appear one cycle after the access. `rd_valid` is raised for loads only, including rejected ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Byte address within the page window |
| acc_size | input | 4 | Access size in bytes; only 8 is accepted |
| queue_enable | input | NUM_Q | Per-queue valid bit |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | 64 | Load response data |
| notify_valid | output | 1 | Forwarding request pulse |
| notify_queue | output | QW | Queue that forwards |
| notify_esc | output | 1 | Forwarding came from the escalation page |
| upd_valid | output | 1 | A field changed value |
| upd_queue | output | QW | Queue whose field changed |
| upd_esc | output | 1 | Changed field is the escalation field |
| upd_pq | output | 2 | New field value |

## Verification
The hardest condition to reach is a field that is already at the value an operation would produce. Examples are a trigger on 11, an EOI on 00, and a set to the current value. In these cases the update strobe must stay quiet while load data is still returned. Directed sequences first drive a field into each of the four states with set-loads. They then apply every operation on top. A long random phase follows over enabled, disabled and out-of-range queues with mixed sizes, and a behavioural model checks every output on every cycle.

// File: rtl/pq_page_ctl.sv
module pq_page_ctl #(
  parameter int NUM_Q      = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 20,
  localparam int QW        = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_size,
  input  logic [NUM_Q-1:0]  queue_enable,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              notify_valid,
  output logic [QW-1:0]     notify_queue,
  output logic              notify_esc,
  output logic              upd_valid,
  output logic [QW-1:0]     upd_queue,
  output logic              upd_esc,
  output logic [1:0]        upd_pq
);

  localparam int IW = ADDR_W - PAGE_SHIFT - 1;

  if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
    $error("PAGE_SHIFT must be 12 or 16");
  end

  logic [1:0] pq_n [NUM_Q];
  logic [1:0] pq_e [NUM_Q];

  logic [IW-1:0] qidx;
  logic [11:0]   off;
  logic          page_esc, in_range, hit;
  logic [QW-1:0] qsel;
  logic [1:0]    cur, nxt, ret;
  logic          fwd, known, commit, change;

  assign qidx     = acc_addr[ADDR_W-1:PAGE_SHIFT+1];
  assign page_esc = acc_addr[PAGE_SHIFT];
  assign off      = acc_addr[11:0];
  assign in_range = 32'(qidx) < NUM_Q;
  assign qsel     = in_range ? qidx[QW-1:0] : '0;
  assign hit      = acc_valid && in_range && queue_enable[qsel] && acc_size == 4'd8;
  assign cur      = page_esc ? pq_e[qsel] : pq_n[qsel];

  function automatic logic [1:0] trig_next(input logic [1:0] s);
    return (s == 2'b00) ? 2'b10 : 2'b11;
  endfunction

  function automatic logic [1:0] eoi_next(input logic [1:0] s);
    return (s == 2'b11) ? 2'b10 : 2'b00;
  endfunction

  always_comb begin
    nxt   = cur;
    ret   = 2'b00;
    fwd   = 1'b0;
    known = 1'b1;
    if (!acc_write) begin
      case (off[11:10])
        2'b00, 2'b01: begin nxt = eoi_next(cur); ret = {1'b0, cur[0]}; end
        2'b10:        ret = cur;
        default:      begin nxt = off[9:8]; ret = cur; end
      endcase
    end else begin
      case (off[11:10])
        2'b00:   begin nxt = trig_next(cur); fwd = (cur == 2'b00); end
        2'b01:   begin nxt = eoi_next(cur);  fwd = cur[0]; end
        2'b10:   fwd = !page_esc;
        default: known = 1'b0;
      endcase
    end
  end

  assign commit = hit && known;
  assign change = commit && (nxt != cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) begin
        pq_n[i] <= 2'b00;
        pq_e[i] <= 2'b00;
      end
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      notify_valid <= 1'b0;
      notify_queue <= '0;
      notify_esc   <= 1'b0;
      upd_valid    <= 1'b0;
      upd_queue    <= '0;
      upd_esc      <= 1'b0;
      upd_pq       <= 2'b00;
    end else begin
      rd_valid     <= acc_valid && !acc_write;
      notify_valid <= commit && fwd;
      upd_valid    <= change;
      if (acc_valid && !acc_write)
        rd_data <= commit ? {62'd0, ret} : '1;
      if (commit && fwd) begin
        notify_queue <= qsel;
        notify_esc   <= page_esc;
      end
      if (change) begin
        if (page_esc) pq_e[qsel] <= nxt;
        else          pq_n[qsel] <= nxt;
        upd_queue <= qsel;
        upd_esc   <= page_esc;
        upd_pq    <= nxt;
      end
    end
  end

endmodule

// File: rtl/pq_page_ctl_chk.sv
module pq_page_ctl_chk #(
  parameter int NUM_Q      = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 20,
  localparam int QW        = $clog2(NUM_Q)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [3:0]        acc_size,
  input logic [NUM_Q-1:0]  queue_enable,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic              notify_valid,
  input logic [QW-1:0]     notify_queue,
  input logic              notify_esc,
  input logic              upd_valid,
  input logic [QW-1:0]     upd_queue,
  input logic              upd_esc,
  input logic [1:0]        upd_pq
);

  AST_RD_ONLY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write)); // R12

  AST_NOTIFY_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(acc_valid && acc_write)); // R6

  AST_UPD_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(acc_valid)); // R11

  AST_INJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[11:10] == 2'b10) |=> !upd_valid); // R8

  AST_ESC_INJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[PAGE_SHIFT] && acc_addr[11:10] == 2'b10) |=> !notify_valid); // R9

  AST_BAD_SIZE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size != 4'd8) |=> (!upd_valid && !notify_valid)); // R10

  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size != 4'd8) |=> (rd_data == '1)); // R10

  AST_GOOD_LOAD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == 4'd8 && (acc_addr >> (PAGE_SHIFT + 1)) < NUM_Q
     && queue_enable[acc_addr[PAGE_SHIFT+QW:PAGE_SHIFT+1]]) |=> (rd_data[63:2] == '0)); // R4

endmodule

bind pq_page_ctl pq_page_ctl_chk #(.NUM_Q(NUM_Q), .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_pq_page_ctl.sv
module test_pq_page_ctl;
  localparam int NQ = 16;
  localparam int PS = 12;
  localparam int AW = 20;
  localparam int QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0] acc_size = 4'd8;
  logic [NQ-1:0] queue_enable = 16'hFF7F;
  logic rd_valid, notify_valid, notify_esc, upd_valid, upd_esc;
  logic [63:0] rd_data;
  logic [QW-1:0] notify_queue, upd_queue;
  logic [1:0] upd_pq;

  always #10 clk = ~clk;

  pq_page_ctl #(.NUM_Q(NQ), .PAGE_SHIFT(PS), .ADDR_W(AW)) i_pq_page_ctl (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1", exp_req = "R1";

  int mn [NQ];
  int me [NQ];
  bit e_rdv, e_nv, e_uv, e_nesc, e_uesc;
  logic [63:0] e_rd;
  int e_nq, e_uq, e_upq;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mn[i]) begin mn[i] = 0; me[i] = 0; end
      e_rdv <= 0; e_nv <= 0; e_uv <= 0;
    end else begin
      int q, pg, off, cur, nx;
      bit ok, fwd, rv;
      logic [63:0] rd;
      q = int'(acc_addr) >> (PS + 1);
      pg = int'(acc_addr[PS]);
      off = int'(acc_addr[11:0]);
      ok = acc_valid && q < NQ && acc_size == 8;
      if (ok) ok = queue_enable[q];
      cur = (ok && pg == 1) ? me[q] : (ok ? mn[q] : 0);
      nx = cur; fwd = 0; rv = 0; rd = '1;
      if (acc_valid && !acc_write) begin
        rv = 1;
        if (ok) begin
          if (off < 'h800) begin rd = cur % 2; nx = (cur == 3) ? 2 : 0; end
          else if (off < 'hC00) rd = cur;
          else begin rd = cur; nx = (off / 256) % 4; end
        end
      end else if (acc_valid && ok) begin
        if (off < 'h400) begin fwd = (cur == 0); nx = (cur == 0) ? 2 : 3; end
        else if (off < 'h800) begin fwd = (cur % 2 == 1); nx = (cur == 3) ? 2 : 0; end
        else if (off < 'hC00) fwd = (pg == 0);
      end
      e_rdv <= rv; e_rd <= rd;
      e_nv <= fwd; e_nq <= q; e_nesc <= pg;
      e_uv <= ok && nx != cur; e_uq <= q; e_uesc <= pg; e_upq <= nx;
      if (ok && nx != cur) begin
        if (pg == 1) me[q] = nx; else mn[q] = nx;
      end
      exp_req <= cur_req;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (rd_valid !== e_rdv || (e_rdv && rd_data !== e_rd)) begin
      errors++;
      $display("FAIL %s load: actual v=%0b d=%h expected v=%0b d=%h", exp_req, rd_valid, rd_data, e_rdv, e_rd);
    end
    if (notify_valid !== e_nv || (e_nv && (int'(notify_queue) != e_nq || notify_esc !== e_nesc))) begin
      errors++;
      $display("FAIL %s notify: actual v=%0b q=%0d esc=%0b expected v=%0b q=%0d esc=%0b",
               exp_req, notify_valid, notify_queue, notify_esc, e_nv, e_nq, e_nesc);
    end
    if (upd_valid !== e_uv || (e_uv && (int'(upd_queue) != e_uq || upd_esc !== e_uesc || int'(upd_pq) != e_upq))) begin
      errors++;
      $display("FAIL %s update: actual v=%0b q=%0d esc=%0b pq=%0d expected v=%0b q=%0d esc=%0b pq=%0d",
               exp_req, upd_valid, upd_queue, upd_esc, upd_pq, e_uv, e_uq, e_uesc, e_upq);
    end
  end

  task automatic acc(input bit w, input int q, input int pg, input int off, input int sz, input string req);
    @(negedge clk);
    cur_req   = req;
    acc_valid = 1'b1;
    acc_write = w;
    acc_addr  = AW'((q << (PS + 1)) | (pg << PS) | off);
    acc_size  = 4'(sz);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd_valid || notify_valid || upd_valid) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %0b%0b%0b expected 000", rd_valid, notify_valid, upd_valid);
    end
    acc(0, 0, 0, 'h800, 8, "R1");
    acc(0, 0, 1, 'h800, 8, "R1");
    acc(1, 1, 0, 'h000, 8, "R6");
    acc(1, 1, 0, 'h3F8, 8, "R6");
    acc(1, 1, 0, 'h100, 8, "R6");
    acc(0, 1, 0, 'hBF8, 8, "R4");
    acc(0, 1, 1, 'h800, 8, "R2");
    acc(0, 1, 0, 'h000, 8, "R3");
    acc(0, 1, 0, 'h7F8, 8, "R3");
    acc(0, 1, 0, 'h400, 8, "R3");
    acc(0, 2, 0, 'hD00, 8, "R5");
    acc(0, 2, 0, 'hD08, 8, "R5");
    acc(1, 2, 0, 'h000, 8, "R6");
    acc(0, 2, 0, 'hC00, 8, "R5");
    acc(0, 2, 0, 'hD00, 8, "R3");
    acc(0, 2, 0, 'h000, 8, "R3");
    acc(0, 3, 0, 'hF00, 8, "R5");
    acc(1, 3, 0, 'h400, 8, "R7");
    acc(1, 3, 0, 'h400, 8, "R7");
    acc(1, 3, 0, 'h400, 8, "R7");
    acc(1, 4, 0, 'h800, 8, "R8");
    acc(0, 4, 0, 'h800, 8, "R8");
    acc(1, 4, 1, 'h800, 8, "R9");
    acc(0, 4, 1, 'h800, 8, "R9");
    acc(1, 5, 1, 'h000, 8, "R6");
    acc(0, 5, 0, 'h800, 8, "R2");
    acc(0, 7, 0, 'h800, 8, "R10");
    acc(1, 7, 0, 'h000, 8, "R10");
    acc(0, 20, 0, 'h800, 8, "R10");
    acc(1, 20, 1, 'h000, 8, "R10");
    acc(0, 6, 0, 'hE00, 4, "R10");
    acc(1, 6, 0, 'h000, 2, "R10");
    acc(1, 6, 0, 'hC00, 8, "R10");
    acc(0, 6, 0, 'h800, 8, "R10");
    acc(0, 0, 0, 'hC00, 8, "R11");
    acc(1, 0, 0, 'h800, 8, "R11");
    idle();
    acc(0, 9, 1, 'h808, 8, "R12");
    idle();
    idle();
    for (int n = 0; n < 4000; n++) begin
      acc($urandom % 2, $urandom % 20, $urandom % 2, ($urandom % 512) * 8,
          ($urandom % 8 == 0) ? 4 : 8, "R2");
      if ($urandom % 5 == 0) idle();
    end
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule